// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for one display interface. It runs on the pixel clock. The vertical side is counted as a single flat pixel count from the frame origin, not as a line number. A frame pixel counter wraps at the programmed frame period, and a line counter wraps at the programmed line length. Each strobe is decoded from these two counters by comparing them with programmed bounds.

Configuration words are captured into a shadow set on a write strobe. The shadow set is copied into the working set while the engine is idle, and at the edge that starts a new frame. A running engine therefore never shows a half-updated timing. Dropping the enable input does not stop the engine at once: it finishes the current frame and stops at the frame boundary, so an enable raised again soon after cannot race the stop.

A fill colour register, which resets to 0xFF, is offered whenever the pixel source reports an underflow inside the visible area.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, running_o, de_o, frame_start_o and fill_en_o are 0, hsync_o and vsync_o are 0 (both polarity bits reset to 0), and fill_color_o is 0xFF.
- R2: While running with skew 0, the line position is the frame position modulo the line length, and hsync is active for the first `hpw` positions of every line.
- R3: The frame position counts 0 to `fper`-1 and then wraps. vsync is active while the frame position is below `vlen`. frame_start_o is 1 exactly when running at frame position 0.
- R4: de_o is 1 only while running with the frame position inside [`vstart`,`vend`] and the line position inside [`hstart`,`hend`], both ranges inclusive.
- R5: `hpol_low`=1 inverts hsync_o, and `vpol_low`=1 inverts vsync_o, each on its own. The inversion also applies while idle, when the pins rest at their inactive level.
- R6: Clearing en_i in the middle of a frame leaves the engine running to the end of that frame. running_o falls one cycle after the last position (`fper`-1).
- R7: A configuration write while running takes effect from the next frame start. A write while idle is in force for the first frame after enable.
- R8: With skew `s` > 0, the line position at frame origin is `htot`-`s`, so the first hsync pulse begins `s` clocks after the frame origin.
- R9: fill_en_o equals de_o AND underflow_i, and fill_color_o shows the working fill colour.
- R10: Raising en_i while idle starts a frame at the next clock edge, with frame_start_o high in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Engine enable level |
| cfg_we | input | 1 | Capture all cfg_* inputs into the shadow set |
| cfg_htot | input | LW | Pixels per line |
| cfg_hpw | input | LW | hsync width in pixels |
| cfg_hstart | input | LW | First visible line position |
| cfg_hend | input | LW | Last visible line position |
| cfg_skew | input | LW | hsync offset from frame origin |
| cfg_fper | input | FW | Frame period in pixel clocks |
| cfg_vlen | input | FW | vsync length in pixel clocks |
| cfg_vstart | input | FW | First visible frame position |
| cfg_vend | input | FW | Last visible frame position |
| cfg_hpol_low | input | 1 | hsync active-low when 1 |
| cfg_vpol_low | input | 1 | vsync active-low when 1 |
| cfg_fill | input | CW | Underflow fill colour |
| underflow_i | input | 1 | Pixel source has no data this cycle |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | One-cycle pulse at frame origin |
| running_o | output | 1 | Engine is running |
| fill_en_o | output | 1 | Substitute the fill colour now |
| fill_color_o | output | CW | Working fill colour |

## Verification
The bound checker checks a set of invariants on every cycle:
- the counters stay below their working periods;
- the frame pulse never appears while idle;
- data enable is quiet while idle;
- the working line length and frame period stay constant between frame starts;
- running only ever falls right after the last position of a frame, with enable low.

Other behaviour can only be shown by the bench scenarios, which compare every output in every cycle against an arithmetic model. These scenarios cover the exact pulse widths, the window edges, the polarity inversion, the skewed line origin, the deferral of a mid-frame write, and the restart after a deferred stop.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
// Package tg_pkg: types shared by the timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package tg_pkg;
    typedef enum logic {TG_IDLE = 1'b0, TG_RUN = 1'b1} tg_state_e;
    localparam int TG_FILL_RESET = 'hFF;
endpackage

// File: rtl/tg_shadow.sv
`timescale 1ns/1ps
// Module tg_shadow: shadow and working configuration sets.
// A write strobe captures the inputs into the shadow set. load_i copies the
// shadow set into the working set. Assumes the fill width is at least 8 bits.
module tg_shadow #(
    parameter int LW = 12,
    parameter int FW = 24,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          load_i,
    input  logic [LW-1:0] in_htot,
    input  logic [LW-1:0] in_hpw,
    input  logic [LW-1:0] in_hstart,
    input  logic [LW-1:0] in_hend,
    input  logic [LW-1:0] in_skew,
    input  logic [FW-1:0] in_fper,
    input  logic [FW-1:0] in_vlen,
    input  logic [FW-1:0] in_vstart,
    input  logic [FW-1:0] in_vend,
    input  logic          in_hpol,
    input  logic          in_vpol,
    input  logic [CW-1:0] in_fill,
    output logic [LW-1:0] sh_htot,
    output logic [LW-1:0] sh_skew,
    output logic [LW-1:0] act_htot,
    output logic [LW-1:0] act_hpw,
    output logic [LW-1:0] act_hstart,
    output logic [LW-1:0] act_hend,
    output logic [FW-1:0] act_fper,
    output logic [FW-1:0] act_vlen,
    output logic [FW-1:0] act_vstart,
    output logic [FW-1:0] act_vend,
    output logic          act_hpol,
    output logic          act_vpol,
    output logic [CW-1:0] act_fill
);
    import tg_pkg::*;
    localparam logic [CW-1:0] FILL_RST = CW'(TG_FILL_RESET);

    logic [LW-1:0] sh_hpw, sh_hstart, sh_hend;
    logic [FW-1:0] sh_fper, sh_vlen, sh_vstart, sh_vend;
    logic          sh_hpol, sh_vpol;
    logic [CW-1:0] sh_fill;

    // Capture the configuration inputs on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_htot <= '0; sh_hpw <= '0; sh_hstart <= '0; sh_hend <= '0; sh_skew <= '0;
            sh_fper <= '0; sh_vlen <= '0; sh_vstart <= '0; sh_vend <= '0;
            sh_hpol <= 1'b0; sh_vpol <= 1'b0; sh_fill <= FILL_RST;
        end else if (we_i) begin
            sh_htot <= in_htot; sh_hpw <= in_hpw; sh_hstart <= in_hstart;
            sh_hend <= in_hend; sh_skew <= in_skew;
            sh_fper <= in_fper; sh_vlen <= in_vlen; sh_vstart <= in_vstart;
            sh_vend <= in_vend; sh_hpol <= in_hpol; sh_vpol <= in_vpol;
            sh_fill <= in_fill;
        end
    end

    // Transfer the shadow set to the working set when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_htot <= '0; act_hpw <= '0; act_hstart <= '0; act_hend <= '0;
            act_fper <= '0; act_vlen <= '0; act_vstart <= '0; act_vend <= '0;
            act_hpol <= 1'b0; act_vpol <= 1'b0; act_fill <= FILL_RST;
        end else if (load_i) begin
            act_htot <= sh_htot; act_hpw <= sh_hpw; act_hstart <= sh_hstart;
            act_hend <= sh_hend; act_fper <= sh_fper; act_vlen <= sh_vlen;
            act_vstart <= sh_vstart; act_vend <= sh_vend;
            act_hpol <= sh_hpol; act_vpol <= sh_vpol; act_fill <= sh_fill;
        end
    end
endmodule

// File: rtl/tg_counters.sv
`timescale 1ns/1ps
// Module tg_counters: run state, frame position counter and line position counter.
// A frame starts at the edge where the enable is seen while idle. A stop
// happens only at the frame wrap. The line origin uses the incoming (shadow)
// line length and skew, because the working set is reloaded at that same edge.
// Assumes fper >= 2, htot >= 1, skew < htot, and fper a multiple of htot.
module tg_counters #(
    parameter int LW = 12,
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [LW-1:0] act_htot,
    input  logic [FW-1:0] act_fper,
    input  logic [LW-1:0] nxt_htot,
    input  logic [LW-1:0] nxt_skew,
    output logic [FW-1:0] fcnt,
    output logic [LW-1:0] hcnt,
    output logic          running,
    output logic          load_o
);
    import tg_pkg::*;
    tg_state_e     state_q;
    logic          last_pix, last_col;
    logic [LW-1:0] h_origin;

    // Detect the frame/line ends and compute where a new frame's line starts.
    always_comb begin
        last_pix = (fcnt == act_fper - FW'(1));
        last_col = (hcnt == act_htot - LW'(1));
        h_origin = (nxt_skew == '0) ? '0 : nxt_htot - nxt_skew;
    end

    assign running = (state_q == TG_RUN);
    assign load_o  = (state_q == TG_IDLE) || last_pix;

    // Advance the counters, start on enable, stop only at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TG_IDLE;
            fcnt    <= '0;
            hcnt    <= '0;
        end else begin
            case (state_q)
                TG_IDLE: if (en_i) begin
                    state_q <= TG_RUN;
                    fcnt    <= '0;
                    hcnt    <= h_origin;
                end
                default: if (last_pix) begin
                    fcnt <= '0;
                    hcnt <= en_i ? h_origin : '0;
                    if (!en_i) state_q <= TG_IDLE;
                end else begin
                    fcnt <= fcnt + FW'(1);
                    hcnt <= last_col ? '0 : hcnt + LW'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/tg_decode.sv
`timescale 1ns/1ps
// Module tg_decode: turns the counter positions into the sync, enable and fill strobes.
// This logic is purely combinational. Window bounds are inclusive, and the
// polarity bits invert the pins whether or not the engine runs.
module tg_decode #(
    parameter int LW = 12,
    parameter int FW = 24
) (
    input  logic          running,
    input  logic [FW-1:0] fcnt,
    input  logic [LW-1:0] hcnt,
    input  logic [LW-1:0] act_hpw,
    input  logic [LW-1:0] act_hstart,
    input  logic [LW-1:0] act_hend,
    input  logic [FW-1:0] act_vlen,
    input  logic [FW-1:0] act_vstart,
    input  logic [FW-1:0] act_vend,
    input  logic          act_hpol,
    input  logic          act_vpol,
    input  logic          underflow_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          frame_start_o,
    output logic          fill_en_o
);
    logic in_h, in_v, hs_act, vs_act;

    // Compare the positions against the working bounds and drive the pins.
    always_comb begin
        hs_act        = running && (hcnt < act_hpw);
        vs_act        = running && (fcnt < act_vlen);
        in_h          = (hcnt >= act_hstart) && (hcnt <= act_hend);
        in_v          = (fcnt >= act_vstart) && (fcnt <= act_vend);
        de_o          = running && in_h && in_v;
        hsync_o       = hs_act ^ act_hpol;
        vsync_o       = vs_act ^ act_vpol;
        frame_start_o = running && (fcnt == '0);
        fill_en_o     = de_o && underflow_i;
    end
endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
// Module disp_timing_gen: the top of the display timing generator.
// It connects the configuration store, the counters and the strobe decoder.
// Assumes the configuration rules stated in tg_counters.
module disp_timing_gen #(
    parameter int LW = 12,
    parameter int FW = 24,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cfg_we,
    input  logic [LW-1:0] cfg_htot,
    input  logic [LW-1:0] cfg_hpw,
    input  logic [LW-1:0] cfg_hstart,
    input  logic [LW-1:0] cfg_hend,
    input  logic [LW-1:0] cfg_skew,
    input  logic [FW-1:0] cfg_fper,
    input  logic [FW-1:0] cfg_vlen,
    input  logic [FW-1:0] cfg_vstart,
    input  logic [FW-1:0] cfg_vend,
    input  logic          cfg_hpol_low,
    input  logic          cfg_vpol_low,
    input  logic [CW-1:0] cfg_fill,
    input  logic          underflow_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          frame_start_o,
    output logic          running_o,
    output logic          fill_en_o,
    output logic [CW-1:0] fill_color_o
);
    logic [LW-1:0] sh_htot, sh_skew, act_htot, act_hpw, act_hstart, act_hend;
    logic [FW-1:0] act_fper, act_vlen, act_vstart, act_vend;
    logic          act_hpol, act_vpol, load;
    logic [FW-1:0] fcnt;
    logic [LW-1:0] hcnt;

    tg_shadow #(.LW(LW), .FW(FW), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .load_i(load),
        .in_htot(cfg_htot), .in_hpw(cfg_hpw), .in_hstart(cfg_hstart),
        .in_hend(cfg_hend), .in_skew(cfg_skew), .in_fper(cfg_fper),
        .in_vlen(cfg_vlen), .in_vstart(cfg_vstart), .in_vend(cfg_vend),
        .in_hpol(cfg_hpol_low), .in_vpol(cfg_vpol_low), .in_fill(cfg_fill),
        .sh_htot(sh_htot), .sh_skew(sh_skew),
        .act_htot(act_htot), .act_hpw(act_hpw), .act_hstart(act_hstart),
        .act_hend(act_hend), .act_fper(act_fper), .act_vlen(act_vlen),
        .act_vstart(act_vstart), .act_vend(act_vend), .act_hpol(act_hpol),
        .act_vpol(act_vpol), .act_fill(fill_color_o)
    );

    tg_counters #(.LW(LW), .FW(FW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .act_htot(act_htot), .act_fper(act_fper),
        .nxt_htot(sh_htot), .nxt_skew(sh_skew),
        .fcnt(fcnt), .hcnt(hcnt), .running(running_o), .load_o(load)
    );

    tg_decode #(.LW(LW), .FW(FW)) u_dec (
        .running(running_o), .fcnt(fcnt), .hcnt(hcnt),
        .act_hpw(act_hpw), .act_hstart(act_hstart), .act_hend(act_hend),
        .act_vlen(act_vlen), .act_vstart(act_vstart), .act_vend(act_vend),
        .act_hpol(act_hpol), .act_vpol(act_vpol), .underflow_i(underflow_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .frame_start_o(frame_start_o), .fill_en_o(fill_en_o)
    );
endmodule

// File: rtl/tg_checker.sv
`timescale 1ns/1ps
// Module tg_checker: invariants of the timing generator, checked on every cycle.
// It is bound into disp_timing_gen and observes ports plus counter state.
module tg_checker #(
    parameter int LW = 12,
    parameter int FW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic          running_o,
    input logic          frame_start_o,
    input logic          de_o,
    input logic [FW-1:0] fcnt,
    input logic [LW-1:0] hcnt,
    input logic [FW-1:0] act_fper,
    input logic [LW-1:0] act_htot
);
    // R1: when idle, neither the data enable nor the frame pulse is active
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> (!de_o && !frame_start_o));

    // R2: the line position stays below the working line length
    p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (hcnt < act_htot));

    // R3: the frame position stays below the working frame period
    p_fcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (fcnt < act_fper));

    // R3: the frame pulse appears only while running
    p_fstart_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> running_o);

    // R6: running falls only after the last frame position, with enable low
    p_stop_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> (($past(fcnt) == $past(act_fper) - FW'(1)) && !$past(en_i)));

    // R7: the working periods stay fixed between frame starts
    p_frozen_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $past(running_o) && fcnt != '0) |-> ($stable(act_htot) && $stable(act_fper)));
endmodule

bind disp_timing_gen tg_checker #(.LW(LW), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .running_o(running_o),
    .frame_start_o(frame_start_o), .de_o(de_o), .fcnt(fcnt), .hcnt(hcnt),
    .act_fper(act_fper), .act_htot(act_htot)
);

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
// Bench sim_disp_timing_gen: models the position counters arithmetically and
// compares every output in every cycle.
module sim_disp_timing_gen;
    localparam int LW = 12, FW = 24, CW = 24;

    typedef struct {
        int htot, hpw, hstart, hend, skew, fper, vlen, vstart, vend, hpol, vpol, fill;
    } cfg_t;

    logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0, cfg_we = 1'b0, underflow_i = 1'b0;
    cfg_t d, n, e;
    logic hsync_o, vsync_o, de_o, frame_start_o, running_o, fill_en_o;
    logic [CW-1:0] fill_color_o;

    int n_chk = 0, n_fail = 0, f = 0, cyc = 0;
    bit mrun = 0;

    always #2.5 clk = ~clk;

    disp_timing_gen #(.LW(LW), .FW(FW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cfg_we(cfg_we),
        .cfg_htot(LW'(d.htot)), .cfg_hpw(LW'(d.hpw)), .cfg_hstart(LW'(d.hstart)),
        .cfg_hend(LW'(d.hend)), .cfg_skew(LW'(d.skew)), .cfg_fper(FW'(d.fper)),
        .cfg_vlen(FW'(d.vlen)), .cfg_vstart(FW'(d.vstart)), .cfg_vend(FW'(d.vend)),
        .cfg_hpol_low(d.hpol[0]), .cfg_vpol_low(d.vpol[0]), .cfg_fill(CW'(d.fill)),
        .underflow_i(underflow_i), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .frame_start_o(frame_start_o), .running_o(running_o), .fill_en_o(fill_en_o),
        .fill_color_o(fill_color_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // One clock: model update from the inputs in force at the edge, then compare.
    task automatic cycle();
        bit pe = en_i, pw = cfg_we, uf = underflow_i;
        int h;
        bit hs, vs, de;
        @(posedge clk); #1;
        cyc++;
        if (mrun) begin
            if (f == e.fper - 1) begin
                f = 0; e = n;
                if (!pe) mrun = 0;
            end else f++;
        end else begin
            e = n;
            if (pe) begin mrun = 1; f = 0; end
        end
        if (pw) n = d;
        if (mrun) begin
            h  = (f + e.htot - e.skew) % e.htot;
            hs = (h < e.hpw);
            vs = (f < e.vlen);
            de = (f >= e.vstart) && (f <= e.vend) && (h >= e.hstart) && (h <= e.hend);
        end else begin
            hs = 0; vs = 0; de = 0;
        end
        chk("R6 running", int'(running_o), int'(mrun));
        chk("R2/R5/R8 hsync", int'(hsync_o), int'(hs ^ e.hpol[0]));
        chk("R3/R5 vsync", int'(vsync_o), int'(vs ^ e.vpol[0]));
        chk("R4 de", int'(de_o), int'(de));
        chk("R3/R10 frame_start", int'(frame_start_o), int'(mrun && f == 0));
        chk("R9 fill_en", int'(fill_en_o), int'(de && uf));
        chk("R9 fill_color", int'(fill_color_o), e.fill);
        underflow_i = (cyc % 3 == 0);
    endtask

    task automatic write_cfg(cfg_t c);
        d = c; cfg_we = 1'b1;
        cycle();
        cfg_we = 1'b0;
    endtask

    initial begin
        cfg_t a, b, c, s;
        a = '{10, 2, 3, 8, 0, 60, 10, 20, 49, 0, 0, 'h123456};
        b = '{12, 3, 5, 10, 4, 72, 24, 24, 59, 1, 1, 'hABCDEF};
        c = '{8, 1, 0, 7, 0, 40, 8, 8, 31, 0, 1, 'h00F0F0};
        d = a;
        n = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 'hFF};
        e = n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk("R1 running", int'(running_o), 0);
        chk("R1 de", int'(de_o), 0);
        chk("R1 hsync", int'(hsync_o), 0);
        chk("R1 vsync", int'(vsync_o), 0);
        chk("R1 frame_start", int'(frame_start_o), 0);
        chk("R1 fill_color", int'(fill_color_o), 'hFF);
        // R7 idle write, R10 start, R2/R3/R4/R9 over two frames
        write_cfg(a);
        cycle();
        en_i = 1'b1;
        for (int i = 0; i < 130; i++) cycle();
        // R7 mid-frame write of B (also R5 polarity, R8 skew) deferred to next frame
        write_cfg(b);
        for (int i = 0; i < 200; i++) cycle();
        // R6: drop enable mid-frame, the frame completes, then idle
        for (int i = 0; i < 10; i++) cycle();
        en_i = 1'b0;
        for (int i = 0; i < 120; i++) cycle();
        // R7 idle write of C, R10 restart
        write_cfg(c);
        cycle();
        en_i = 1'b1;
        for (int i = 0; i < 90; i++) cycle();
        // Sweep of skew and pulse width, each run stopped at a frame boundary (R8, R2, R6)
        for (int k = 0; k < 4; k++) begin
            en_i = 1'b0;
            for (int i = 0; i < 45; i++) cycle();
            s = '{8, k + 1, 2, 6, k, 32, 8 + 8 * k, 8, 23, k % 2, (k / 2) % 2, 16 * k};
            write_cfg(s);
            cycle();
            en_i = 1'b1;
            for (int i = 0; i < 70; i++) cycle();
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule